// File: doc/BRIEF.md
# Reference-Timed Clock Frequency Meter

This block estimates how fast one of several source clocks runs by counting its edges over a window timed by the block's own reference clock, whose rate software supplies in kHz. Each source reaches the block as a toggle signal that flips once per source edge. The toggle passes through a two-flop synchroniser, and a change detector turns every flip into a one-cycle pulse in the reference domain.

Software sets the reference rate, the window exponent and a pair of kHz limits. It then writes a source number, and that write is the only start command. While the window is open the block raises a busy flag. When the window closes it drops the busy flag and raises a ready flag together with:
- a fixed-point kHz result;
- exactly one of three verdict flags, which compare the integer part of the result with the limits.

Software polls the two flags, and must not issue a new source write while busy. A write made while busy is ignored.

Top module: `refclk_freq_meter`

## Requirements
- R1: While reset is held low, `running`, `done`, `pass`, `fast`, `slow` and `result` are all zero.
- R2: A `src_sel_wr` pulse seen at a clock edge while `running` is low starts a measurement. From the next cycle `running` is 1, and `done` and `result` are both 0.
- R3: `running` stays high for exactly 2^W reference cycles, where W is the `interval` value captured at the start. This holds for every source number, including the null ones.
- R4: `done` rises in the same cycle that `running` falls. It keeps its value, together with `result` and the verdict flags, until the next accepted start.
- R5: A `src_sel_wr` pulse while `running` is high is ignored. It changes neither the window length nor the source being measured.
- R6: `result` is (E * K * 2^FRAC_W) / 2^W, truncated and saturated at its full width. Here E is the number of source edges counted, K is the captured reference kHz, and FRAC_W defaults to 5. The integer kHz value occupies bits `result[RES_W-1:FRAC_W]`. E is within one count of the number of toggles in any window of 2^W consecutive cycles, and it is exact for a source that toggles every cycle.
- R7: Source number 0, or any number above NSRC, is a null source. A measurement on a null source still runs the full window and reports `result` = 0. Source number k, for 1..NSRC, measures `src_tgl[k-1]`.
- R8: When `done` rises, exactly one verdict flag is set. `slow` is set when the integer kHz is below the minimum limit. `fast` is set when it is above the maximum limit. `pass` is set otherwise, so limits of 0 and all-ones always yield `pass`.
- R9: The reference kHz, window exponent and both limits are captured at the start. Changing those inputs while `running` is high has no effect on the measurement in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tgl | input | NSRC | One toggle per source edge, one bit per source |
| src_sel | input | SEL_W | Source number to measure (0 = null) |
| src_sel_wr | input | 1 | Write strobe for the source number; starts a measurement |
| ref_khz | input | KHZ_W | Reference clock rate in kHz |
| interval | input | IVL_W | Window exponent W; window is 2^W cycles |
| min_khz | input | KHZ_W | Lower kHz limit |
| max_khz | input | KHZ_W | Upper kHz limit |
| running | output | 1 | Measurement window open |
| done | output | 1 | Result and verdict valid |
| result | output | RES_W | Fixed-point kHz, FRAC_W fractional bits |
| pass | output | 1 | Integer kHz within limits |
| fast | output | 1 | Integer kHz above maximum |
| slow | output | 1 | Integer kHz below minimum |

## Verification
The first pattern is a source that toggles every cycle, measured under several window exponents and reference rates. This pins the scaling exactly, because the result must equal the reference kHz shifted by the fraction width. The second pattern uses sources toggling every third and every seventh cycle. These check the counting path against a one-count tolerance band, which separates a correct edge count from a lost synchroniser stage or a wrong shift. The third pattern uses the null source numbers, which show that window timing does not depend on source activity. The fourth pattern is a rewrite of the source number and the configuration mid-window, which separates a block that latches its settings from one that follows its inputs.

// File: rtl/fm_pkg.sv
package fm_pkg;

  typedef enum logic [1:0] {
    LIM_PASS = 2'd0,
    LIM_SLOW = 2'd1,
    LIM_FAST = 2'd2
  } lim_e;

  // Limit verdict on the integer kHz value.
  function automatic lim_e judge(input logic [31:0] khz,
                                 input logic [31:0] lo,
                                 input logic [31:0] hi);
    if (khz < lo)      return LIM_SLOW;
    else if (khz > hi) return LIM_FAST;
    else               return LIM_PASS;
  endfunction

endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl,
  output logic pulse
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= tgl;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign pulse = s2 ^ s3;
endmodule

// File: rtl/fm_window.sv
module fm_window #(
  parameter int IVL_W = 4,
  localparam int WIN_W = 2 ** IVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IVL_W-1:0] ivl,
  output logic             running,
  output logic             win_end
);
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] last_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      cnt_q  <= '0;
      last_q <= (WIN_W'(1) << ivl) - WIN_W'(1);
    end else if (run_q) begin
      if (cnt_q == last_q) run_q <= 1'b0;
      else                 cnt_q <= cnt_q + WIN_W'(1);
    end
  end

  assign running = run_q;
  assign win_end = run_q && (cnt_q == last_q);

  // R3: the cycle counter never passes the captured window end
  p_win_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= last_q));
endmodule

// File: rtl/fm_accum.sv
module fm_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] total
);
  logic [CNT_W-1:0] count_q;

  // Running total including this cycle's edge, saturating.
  assign total = (inc && (count_q != '1)) ? count_q + CNT_W'(1) : count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    count_q <= '0;
    else if (clr)  count_q <= '0;
    else           count_q <= total;
  end
endmodule

// File: rtl/refclk_freq_meter.sv
module refclk_freq_meter
  import fm_pkg::*;
#(
  parameter int NSRC   = 4,
  parameter int IVL_W  = 4,
  parameter int KHZ_W  = 25,
  parameter int FRAC_W = 5,
  localparam int SEL_W = $clog2(NSRC + 1),
  localparam int RES_W = KHZ_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tgl,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             src_sel_wr,
  input  logic [KHZ_W-1:0] ref_khz,
  input  logic [IVL_W-1:0] interval,
  input  logic [KHZ_W-1:0] min_khz,
  input  logic [KHZ_W-1:0] max_khz,
  output logic             running,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             pass,
  output logic             fast,
  output logic             slow
);
  localparam int WIN_W  = 2 ** IVL_W;
  localparam int PROD_W = WIN_W + KHZ_W + FRAC_W;

  // edges * ref * 2^FRAC / 2^ivl, saturated to the result width
  function automatic logic [RES_W-1:0] scale_khz(input logic [WIN_W-1:0] edges,
                                                 input logic [KHZ_W-1:0] refk,
                                                 input logic [IVL_W-1:0] ivl);
    logic [PROD_W-1:0] wide;
    wide = (PROD_W'(edges) * PROD_W'(refk)) << FRAC_W;
    wide = wide >> ivl;
    if (|wide[PROD_W-1:RES_W]) return '1;
    return wide[RES_W-1:0];
  endfunction

  // Named internal events
  logic             start;
  logic             win_end;
  logic             sel_pulse;
  logic [NSRC-1:0]  edge_p;
  logic [WIN_W-1:0] edge_total;
  logic [RES_W-1:0] scaled;
  lim_e             verdict;
  logic             null_q;

  // Captured configuration
  logic [SEL_W-1:0] sel_q;
  logic [KHZ_W-1:0] ref_q, min_q, max_q;
  logic [IVL_W-1:0] ivl_q;

  logic             done_q, pass_q, fast_q, slow_q;
  logic [RES_W-1:0] result_q;

  assign start = src_sel_wr && !running;

  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    fm_edge_sync u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .tgl   (src_tgl[g]),
      .pulse (edge_p[g])
    );
  end

  always_comb begin
    sel_pulse = 1'b0;
    for (int k = 1; k <= NSRC; k++) begin
      if (sel_q == SEL_W'(k)) sel_pulse = edge_p[k-1];
    end
  end

  assign null_q = (sel_q == '0) || (sel_q > SEL_W'(NSRC));

  fm_window #(.IVL_W(IVL_W)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .ivl     (interval),
    .running (running),
    .win_end (win_end)
  );

  fm_accum #(.CNT_W(WIN_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .inc   (running && sel_pulse),
    .total (edge_total)
  );

  assign scaled  = scale_khz(edge_total, ref_q, ivl_q);
  assign verdict = judge(32'(scaled[RES_W-1:FRAC_W]), 32'(min_q), 32'(max_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      ref_q    <= '0;
      min_q    <= '0;
      max_q    <= '0;
      ivl_q    <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
      pass_q   <= 1'b0;
      fast_q   <= 1'b0;
      slow_q   <= 1'b0;
    end else if (start) begin
      sel_q    <= src_sel;
      ref_q    <= ref_khz;
      min_q    <= min_khz;
      max_q    <= max_khz;
      ivl_q    <= interval;
      done_q   <= 1'b0;
      result_q <= '0;
      pass_q   <= 1'b0;
      fast_q   <= 1'b0;
      slow_q   <= 1'b0;
    end else if (win_end) begin
      done_q   <= 1'b1;
      result_q <= scaled;
      pass_q   <= (verdict == LIM_PASS);
      fast_q   <= (verdict == LIM_FAST);
      slow_q   <= (verdict == LIM_SLOW);
    end
  end

  assign done   = done_q;
  assign result = result_q;
  assign pass   = pass_q;
  assign fast   = fast_q;
  assign slow   = slow_q;

  // R2: an accepted write opens the window and clears the ready flag
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_wr && !running) |=> (running && !done));

  // R4: ready appears as the window closes
  p_done_on_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> done);

  // R5: source number cannot change inside the window
  p_sel_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !win_end) |=> $stable(sel_q));

  // R9: captured reference and exponent stay put inside the window
  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !win_end) |=> ($stable(ref_q) && $stable(ivl_q)));

  // R7: null source reports zero
  p_null_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && null_q) |-> (result == '0));

  // R8: one verdict when ready, none otherwise
  p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({pass, fast, slow}) == 1));
  p_no_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($countones({pass, fast, slow}) == 0));
endmodule

// File: tb/refclk_freq_meter_tb.sv
module refclk_freq_meter_tb;
  localparam int NSRC = 4, IVL_W = 4, KHZ_W = 25, FRAC_W = 5;
  localparam int SEL_W = 3, RES_W = KHZ_W + FRAC_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NSRC-1:0]  src_tgl = '0;
  logic [SEL_W-1:0] src_sel = '0;
  logic             src_sel_wr = 1'b0;
  logic [KHZ_W-1:0] ref_khz = '0;
  logic [IVL_W-1:0] interval = '0;
  logic [KHZ_W-1:0] min_khz = '0;
  logic [KHZ_W-1:0] max_khz = '1;
  logic             running, done, pass, fast, slow;
  logic [RES_W-1:0] result;

  int checks = 0;
  int fails = 0;
  int per [NSRC] = '{1, 3, 7, 5};
  int ph  [NSRC] = '{0, 0, 0, 0};

  // Behavioural model of the flags
  bit m_run = 0;
  bit m_done = 0;
  int m_left = 0;

  always #10 clk = ~clk;

  refclk_freq_meter u_dut (
    .clk(clk), .rst_n(rst_n), .src_tgl(src_tgl), .src_sel(src_sel),
    .src_sel_wr(src_sel_wr), .ref_khz(ref_khz), .interval(interval),
    .min_khz(min_khz), .max_khz(max_khz), .running(running), .done(done),
    .result(result), .pass(pass), .fast(fast), .slow(slow)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Source toggles, one flip every per[k] cycles
  always @(negedge clk) begin
    for (int k = 0; k < NSRC; k++) begin
      ph[k] = ph[k] + 1;
      if (ph[k] >= per[k]) begin
        ph[k] = 0;
        src_tgl[k] = ~src_tgl[k];
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_left = 0;
    end else if (m_run) begin
      m_left = m_left - 1;
      if (m_left == 0) begin m_run = 0; m_done = 1; end
    end else if (src_sel_wr) begin
      m_run = 1; m_done = 0; m_left = 1 << interval;
    end
  end

  // R3 R4: flags compared with the model every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      chk(running === m_run, "R3 running", longint'(running), longint'(m_run));
      chk(done === m_done, "R4 done", longint'(done), longint'(m_done));
    end
  end

  function automatic longint scaled(input longint e, input longint rk, input int w);
    longint v;
    v = (e * rk * (64'd1 << FRAC_W)) / (64'd1 << w);
    if (v > (64'd1 << RES_W) - 1) v = (64'd1 << RES_W) - 1;
    return v;
  endfunction

  task automatic launch(input int sel, input int w, input longint rk,
                        input longint mn, input longint mx);
    @(negedge clk);
    src_sel = SEL_W'(sel); interval = IVL_W'(w); ref_khz = KHZ_W'(rk);
    min_khz = KHZ_W'(mn); max_khz = KHZ_W'(mx); src_sel_wr = 1'b1;
    @(negedge clk);
    src_sel_wr = 1'b0;
    chk(running && !done && result == 0, "R2 start", longint'(result), 0);
  endtask

  task automatic finish_meas();
    while (!done) @(negedge clk);
  endtask

  longint lo, hi, keep;
  localparam longint ALL1 = (64'd1 << KHZ_W) - 1;

  initial begin
    repeat (4) @(negedge clk);
    chk(!running && !done && !pass && !fast && !slow && result == 0, "R1 reset",
        longint'(result), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 exact: every-cycle source
    launch(1, 4, 1000, 0, ALL1); finish_meas();
    chk(result == 32000, "R6 src1 w4", longint'(result), 32000);
    chk(pass && !fast && !slow, "R8 open limits", longint'({pass, fast, slow}), 4);
    keep = longint'(result);
    repeat (5) @(negedge clk);
    chk(done && result == keep, "R4 hold", longint'(result), keep);

    launch(1, 10, 12000, 0, ALL1); finish_meas();
    chk(result == 384000, "R6 src1 w10", longint'(result), 384000);

    // R6 banded: period 3 and 7 sources
    launch(2, 6, 3000, 0, ALL1); finish_meas();
    lo = scaled(64 / 3 - 1, 3000, 6); hi = scaled(64 / 3 + 2, 3000, 6);
    chk(result >= lo && result <= hi, "R6 src2 band", longint'(result), lo);

    launch(3, 8, 777, 0, ALL1); finish_meas();
    lo = scaled(256 / 7 - 1, 777, 8); hi = scaled(256 / 7 + 2, 777, 8);
    chk(result >= lo && result <= hi, "R6 src3 band", longint'(result), lo);

    // R7 null sources
    launch(0, 3, 5000, 0, ALL1); finish_meas();
    chk(result == 0, "R7 sel0", longint'(result), 0);
    launch(6, 5, 5000, 0, ALL1); finish_meas();
    chk(result == 0, "R7 sel6", longint'(result), 0);

    // R8 limits, integer kHz equals the reference for src1
    launch(1, 4, 500, 501, ALL1); finish_meas();
    chk(slow && !pass && !fast, "R8 slow", longint'({pass, fast, slow}), 1);
    launch(1, 4, 500, 0, 499); finish_meas();
    chk(fast && !pass && !slow, "R8 fast", longint'({pass, fast, slow}), 2);
    launch(1, 4, 500, 500, 500); finish_meas();
    chk(pass && !fast && !slow, "R8 edge pass", longint'({pass, fast, slow}), 4);

    // R5 and R9: rewrite source and settings inside the window
    launch(1, 5, 2000, 0, ALL1);
    repeat (3) @(negedge clk);
    src_sel = 3'd0; interval = 4'd2; ref_khz = 25'd9; min_khz = '1;
    src_sel_wr = 1'b1;
    @(negedge clk);
    src_sel_wr = 1'b0;
    chk(running, "R5 still running", longint'(running), 1);
    finish_meas();
    chk(result == 64000, "R5 R9 latched", longint'(result), 64000);
    chk(pass, "R9 limits latched", longint'(pass), 1);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule